// File: doc/BRIEF.md
# Receive PHY Bring-Up Sequencer

This block powers up a multi-lane high-speed receive PHY through its static mode pins and its serial test-configuration port. A start pulse samples a requested line rate in Mbps and a lane count. The block converts the rate into a 6-bit frequency-band code using a fixed table of band upper limits. If the rate falls outside every band, or the lane count is not between one and four, the request is refused and the error flag is raised.

An accepted request runs a fixed bring-up sequence. The block first sets the mode pins and the lane enables. It then raises the test clock and pulses the test-clear line, with a timed wait on each side of the release. Last, it performs seven test-port writes in a fixed order. Each write is built from six single-signal steps. Every step is held for a parameterised number of cycles, and the two clear waits are measured in microseconds from the system clock frequency. A separate power-off input drops the lane enables at any time.

Top module: `rxphy_bringup`

## Requirements
- R1: The band code is the code of the lowest table entry whose upper limit is at least the requested rate. Examples: rate 0 to 89 gives 0x00, 90 to 99 gives 0x10, 250 to 269 gives 0x04, and 1450 to 1500 gives 0x3C. The code is placed in bits 6:1 of the data byte of each data-lane write.
- R2: A start request is refused when the rate exceeds 1500 or the lane count is 0 or above 4. On the next cycle error is 1 and busy stays 0, and no test-port activity follows.
- R3: On the edge that accepts a start, busy goes to 1, turn_dis goes to 0xF, and force_rx, force_stop and turn_req go to 0.
- R4: On that same edge, lane_en is set to a mask with its low N bits set, where N is the lane count.
- R5: HOLD cycles after acceptance, test_clk rises. After another HOLD cycles, test_clr rises and stays high for WAIT cycles, where WAIT = CLK_FREQ_HZ/1e6 * WAIT_US. After release, a further WAIT cycles pass before the first write.
- R6: Each write is six steps, one signal change per step, each held HOLD cycles: test_din takes the code, test_en rises, test_clk falls, test_en falls, test_din takes the data, and test_clk rises.
- R7: The writes are, in order (code, data): (0x34, 0), then (0x44, 0x54, 0x84, 0x94 each with band code shifted left by one), then (0x75, 0x04), then (0x00, 0x00).
- R8: HOLD cycles after the last step, done rises and busy falls. done stays high until the next accepted or refused start.
- R9: Start pulses while busy is high are ignored, and the running sequence keeps its timing and data.
- R10: power_off clears lane_en on the next edge, whether or not a sequence is running.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled when idle |
| rate_mbps | input | 11 | Requested line rate in Mbps |
| lane_count | input | 3 | Number of data lanes, 1 to 4 |
| power_off | input | 1 | Clear the lane enables |
| force_rx | output | 4 | Per-lane forced receive mode |
| force_stop | output | 4 | Per-lane forced stop state |
| turn_req | output | 4 | Per-lane turnaround request |
| turn_dis | output | 4 | Per-lane turnaround disable |
| lane_en | output | 4 | Per-lane enable |
| test_clk | output | 1 | Test-port clock |
| test_clr | output | 1 | Test-port clear |
| test_en | output | 1 | Test-port enable (code phase) |
| test_din | output | 8 | Test-port code/data byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| error | output | 1 | Last request refused |

## Verification
Mode pins and lane enables change on the edge that samples start. The test clock follows HOLD cycles later and the clear pulse HOLD cycles after that. Write step s (0 to 41) lands 2*HOLD + 2*WAIT + s*HOLD cycles after acceptance, and done arrives at step 42. A refusal shows on error one cycle after start, and power_off shows on lane_en one cycle after it is driven. The bench model counts the same offsets from the accepting edge, and every output is compared on each falling edge, so each value is checked in the cycle it is due. The code and data bytes seen at each test-clock edge are also collected and compared with the expected write list after every run.

// File: rtl/rxphy_seq_pkg.sv
package rxphy_seq_pkg;

    localparam int NUM_LANES  = 4;
    localparam int RATE_W     = 11;
    localparam int RANGE_W    = 6;
    localparam int NUM_RANGES = 39;
    localparam int NUM_WRITES = 7;
    localparam int NUM_PHASES = 6;
    localparam int IDX_W      = $clog2(NUM_WRITES);
    localparam int PH_W       = $clog2(NUM_PHASES);

    // Each entry: {upper rate limit in Mbps, band code}; searched lowest first.
    localparam logic [RATE_W+RANGE_W-1:0] RANGE_TAB [NUM_RANGES] = '{
        {11'd89,   6'h00}, {11'd99,   6'h10}, {11'd109,  6'h20}, {11'd129,  6'h01},
        {11'd139,  6'h11}, {11'd149,  6'h21}, {11'd169,  6'h02}, {11'd179,  6'h12},
        {11'd199,  6'h22}, {11'd219,  6'h03}, {11'd239,  6'h13}, {11'd249,  6'h23},
        {11'd269,  6'h04}, {11'd299,  6'h14}, {11'd329,  6'h05}, {11'd359,  6'h15},
        {11'd399,  6'h25}, {11'd449,  6'h06}, {11'd499,  6'h16}, {11'd549,  6'h07},
        {11'd599,  6'h17}, {11'd649,  6'h08}, {11'd699,  6'h18}, {11'd749,  6'h09},
        {11'd799,  6'h19}, {11'd849,  6'h29}, {11'd899,  6'h39}, {11'd949,  6'h0a},
        {11'd999,  6'h1a}, {11'd1049, 6'h2a}, {11'd1099, 6'h3a}, {11'd1149, 6'h0b},
        {11'd1199, 6'h1b}, {11'd1249, 6'h2b}, {11'd1299, 6'h3b}, {11'd1349, 6'h0c},
        {11'd1399, 6'h1c}, {11'd1449, 6'h2c}, {11'd1500, 6'h3c}
    };

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STATIC,
        SQ_CLK_HI,
        SQ_CLR_ON,
        SQ_CLR_REL,
        SQ_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [NUM_LANES-1:0] force_rx;
        logic [NUM_LANES-1:0] force_stop;
        logic [NUM_LANES-1:0] turn_req;
        logic [NUM_LANES-1:0] turn_dis;
        logic [NUM_LANES-1:0] lane_en;
    } mode_ctrl_t;

    typedef struct packed {
        logic       tclk;
        logic       tclr;
        logic       ten;
        logic [7:0] tdin;
    } test_port_t;

    // Target register code of write number widx (order is behaviour).
    function automatic logic [7:0] wr_code(logic [IDX_W-1:0] widx);
        case (widx)
            3'd0:    return 8'h34;
            3'd1:    return 8'h44;
            3'd2:    return 8'h54;
            3'd3:    return 8'h84;
            3'd4:    return 8'h94;
            3'd5:    return 8'h75;
            default: return 8'h00;
        endcase
    endfunction

    // Data byte of write number widx.
    function automatic logic [7:0] wr_data(logic [IDX_W-1:0] widx, logic [RANGE_W-1:0] rc);
        case (widx)
            3'd0, 3'd6: return 8'h00;
            3'd5:       return 8'h04;
            default:    return {1'b0, rc, 1'b0};
        endcase
    endfunction

    // Apply one of the six single-signal steps of a write.
    function automatic test_port_t step_port(test_port_t cur, logic [IDX_W-1:0] widx,
                                             logic [PH_W-1:0] wph, logic [RANGE_W-1:0] rc);
        test_port_t nxt;
        nxt = cur;
        case (wph)
            3'd0:    nxt.tdin = wr_code(widx);
            3'd1:    nxt.ten  = 1'b1;
            3'd2:    nxt.tclk = 1'b0;
            3'd3:    nxt.ten  = 1'b0;
            3'd4:    nxt.tdin = wr_data(widx, rc);
            default: nxt.tclk = 1'b1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rxphy_rate_lut.sv
module rxphy_rate_lut
    import rxphy_seq_pkg::*;
(
    input  logic [RATE_W-1:0]  rate,
    output logic               hit,
    output logic [RANGE_W-1:0] code
);
    always_comb begin
        hit  = 1'b0;
        code = '0;
        // Scan from the top so the lowest matching entry wins.
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (rate <= RANGE_TAB[i][RATE_W+RANGE_W-1:RANGE_W]) begin
                hit  = 1'b1;
                code = RANGE_TAB[i][RANGE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rxphy_step_timer.sv
module rxphy_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rxphy_bringup.sv
module rxphy_bringup
    import rxphy_seq_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int WAIT_US     = 100,
    parameter int HOLD_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [RATE_W-1:0]    rate_mbps,
    input  logic [2:0]           lane_count,
    input  logic                 power_off,
    output logic [NUM_LANES-1:0] force_rx,
    output logic [NUM_LANES-1:0] force_stop,
    output logic [NUM_LANES-1:0] turn_req,
    output logic [NUM_LANES-1:0] turn_dis,
    output logic [NUM_LANES-1:0] lane_en,
    output logic                 test_clk,
    output logic                 test_clr,
    output logic                 test_en,
    output logic [7:0]           test_din,
    output logic                 busy,
    output logic                 done,
    output logic                 error
);
    localparam int WAIT_CYCLES = (CLK_FREQ_HZ / 1_000_000) * WAIT_US;
    localparam int MAX_LEN     = (WAIT_CYCLES > HOLD_CYCLES) ? WAIT_CYCLES : HOLD_CYCLES;
    localparam int CNT_W       = $clog2(MAX_LEN + 1);

    seq_state_e           state;
    mode_ctrl_t           mc;
    test_port_t           tp;
    logic [IDX_W-1:0]     widx;
    logic [PH_W-1:0]      wph;
    logic [RANGE_W-1:0]   code_q;
    logic                 done_q, err_q;

    logic                 lut_hit;
    logic [RANGE_W-1:0]   lut_code;
    logic [NUM_LANES-1:0] lane_mask;
    logic                 lanes_ok, accept;
    logic                 expired, t_load, long_next;
    logic [CNT_W-1:0]     t_val;

    rxphy_rate_lut u_lut (
        .rate (rate_mbps),
        .hit  (lut_hit),
        .code (lut_code)
    );

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++)
            lane_mask[i] = (3'(i) < lane_count);
    end

    assign lanes_ok  = (lane_count != 3'd0) && (lane_count <= 3'(NUM_LANES));
    assign accept    = lut_hit && lanes_ok;

    // Steps entered from CLK_HI and CLR_ON are the two long waits.
    assign long_next = (state == SQ_CLK_HI) || (state == SQ_CLR_ON);
    assign t_load    = ((state == SQ_IDLE) && start && accept) ||
                       ((state != SQ_IDLE) && expired);
    assign t_val     = long_next ? CNT_W'(WAIT_CYCLES - 1) : CNT_W'(HOLD_CYCLES - 1);

    rxphy_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            mc     <= '0;
            tp     <= '0;
            widx   <= '0;
            wph    <= '0;
            code_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        if (accept) begin
                            err_q         <= 1'b0;
                            code_q        <= lut_code;
                            mc.force_rx   <= '0;
                            mc.force_stop <= '0;
                            mc.turn_req   <= '0;
                            mc.turn_dis   <= '1;
                            mc.lane_en    <= lane_mask;
                            state         <= SQ_STATIC;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                SQ_STATIC: if (expired) begin
                    tp.tclk <= 1'b1;
                    state   <= SQ_CLK_HI;
                end
                SQ_CLK_HI: if (expired) begin
                    tp.tclr <= 1'b1;
                    state   <= SQ_CLR_ON;
                end
                SQ_CLR_ON: if (expired) begin
                    tp.tclr <= 1'b0;
                    state   <= SQ_CLR_REL;
                end
                SQ_CLR_REL: if (expired) begin
                    tp    <= step_port(tp, '0, '0, code_q);
                    widx  <= '0;
                    wph   <= '0;
                    state <= SQ_WRITE;
                end
                SQ_WRITE: if (expired) begin
                    if (wph == PH_W'(NUM_PHASES - 1)) begin
                        if (widx == IDX_W'(NUM_WRITES - 1)) begin
                            done_q <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            widx <= widx + 1'b1;
                            wph  <= '0;
                            tp   <= step_port(tp, IDX_W'(widx + 1'b1), '0, code_q);
                        end
                    end else begin
                        wph <= wph + 1'b1;
                        tp  <= step_port(tp, widx, PH_W'(wph + 1'b1), code_q);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
            if (power_off)
                mc.lane_en <= '0;
        end
    end

    assign force_rx   = mc.force_rx;
    assign force_stop = mc.force_stop;
    assign turn_req   = mc.turn_req;
    assign turn_dis   = mc.turn_dis;
    assign lane_en    = mc.lane_en;
    assign test_clk   = tp.tclk;
    assign test_clr   = tp.tclr;
    assign test_en    = tp.ten;
    assign test_din   = tp.tdin;
    assign busy       = (state != SQ_IDLE);
    assign done       = done_q;
    assign error      = err_q;

    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R4
    lane_mask_form_chk: assert property (@(posedge clk) disable iff (rst)
        ((lane_en & NUM_LANES'(lane_en + 1'b1)) == '0));

    // R10
    pwr_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        power_off |=> (lane_en == '0));

    // R6
    code_latch_en_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(test_clk) |-> test_en);

    // R5
    clear_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        test_clr |-> busy);

    // R9
    busy_start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !accept) |=> (error && !busy));

endmodule

// File: tb/tb_rxphy_bringup.sv
module tb_rxphy_bringup;
    localparam int FREQ  = 2_000_000;
    localparam int WUS   = 10;
    localparam int H     = 3;
    localparam int W     = (FREQ / 1_000_000) * WUS;
    localparam int TOTAL = 2 * H + 2 * W + 42 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] rate_i = '0;
    logic [2:0]  lanes_i = '0;
    logic        pwr_off = 1'b0;
    logic [3:0]  force_rx, force_stop, turn_req, turn_dis, lane_en;
    logic        test_clk, test_clr, test_en, busy, done, error;
    logic [7:0]  test_din;

    rxphy_bringup #(.CLK_FREQ_HZ(FREQ), .WAIT_US(WUS), .HOLD_CYCLES(H)) dut (
        .clk(clk), .rst(rst), .start(start), .rate_mbps(rate_i), .lane_count(lanes_i),
        .power_off(pwr_off), .force_rx(force_rx), .force_stop(force_stop),
        .turn_req(turn_req), .turn_dis(turn_dis), .lane_en(lane_en),
        .test_clk(test_clk), .test_clr(test_clr), .test_en(test_en),
        .test_din(test_din), .busy(busy), .done(done), .error(error)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    int bnd [39] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269,
                     299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849,
                     899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399,
                     1449, 1500};
    int bcode [39] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                       'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                       'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                       'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};

    function automatic int ref_code(int rate);
        for (int i = 0; i < 39; i++)
            if (rate <= bnd[i]) return bcode[i];
        return -1;
    endfunction

    function automatic int exp_code(int k);
        int lst [7] = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};
        return lst[k];
    endfunction

    function automatic int exp_data(int k, int c);
        if (k == 0 || k == 6) return 0;
        if (k == 5) return 4;
        return c * 2;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference model: time offsets from the accepting edge.
    bit   m_busy, m_done, m_err, m_tclk, m_tclr, m_ten;
    int   m_t, m_code, c_tmp, tn, s_idx;
    logic [3:0] m_tdis, m_lane;
    logic [7:0] m_tdin;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_err <= 0; m_tclk <= 0; m_tclr <= 0; m_ten <= 0;
            m_t <= 0; m_code <= 0; m_tdis <= 0; m_lane <= 0; m_tdin <= 0;
        end else begin
            if (!m_busy) begin
                if (start) begin
                    c_tmp = ref_code(int'(rate_i));
                    m_done <= 0;
                    if (c_tmp < 0 || lanes_i == 0 || lanes_i > 4) begin
                        m_err <= 1;
                    end else begin
                        m_err  <= 0;
                        m_busy <= 1;
                        m_t    <= 0;
                        m_code <= c_tmp;
                        m_tdis <= 4'hF;
                        m_lane <= 4'((1 << lanes_i) - 1);
                    end
                end
            end else begin
                tn = m_t + 1;
                m_t <= tn;
                if (tn == H)         m_tclk <= 1;
                if (tn == 2 * H)     m_tclr <= 1;
                if (tn == 2 * H + W) m_tclr <= 0;
                if (tn >= 2 * H + 2 * W && (tn - 2 * H - 2 * W) % H == 0) begin
                    s_idx = (tn - 2 * H - 2 * W) / H;
                    if (s_idx == 42) begin
                        m_busy <= 0;
                        m_done <= 1;
                    end else begin
                        case (s_idx % 6)
                            0: m_tdin <= 8'(exp_code(s_idx / 6));
                            1: m_ten  <= 1;
                            2: m_tclk <= 0;
                            3: m_ten  <= 0;
                            4: m_tdin <= 8'(exp_data(s_idx / 6, m_code));
                            default: m_tclk <= 1;
                        endcase
                    end
                end
            end
            if (pwr_off) m_lane <= 0;
        end
    end

    // Per-cycle comparison and capture of test-port bytes.
    logic prev_tclk = 1'b0;
    int cq[$];
    int dq[$];

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3/R11 mode pins", {force_rx, force_stop, turn_req, turn_dis},
                {12'h000, m_tdis});
            chk("R4/R10 lane_en", lane_en, m_lane);
            chk("R5 test_clk", test_clk, m_tclk);
            chk("R5 test_clr", test_clr, m_tclr);
            chk("R6 test_en", test_en, m_ten);
            chk("R6/R7 test_din", test_din, m_tdin);
            chk("R8/R9 busy", busy, m_busy);
            chk("R8 done", done, m_done);
            chk("R2 error", error, m_err);
            if (prev_tclk && !test_clk) cq.push_back(int'(test_din));
            if (!prev_tclk && test_clk && cq.size() > dq.size()) dq.push_back(int'(test_din));
        end
        prev_tclk <= test_clk;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                n_err++;
                n_chk++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    task automatic run(int rate, int lanes, int busy_start_at, int poff_at);
        int ec;
        ec = ref_code(rate);
        cq.delete();
        dq.delete();
        @(negedge clk);
        rate_i  = 11'(rate);
        lanes_i = 3'(lanes);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < TOTAL + 3; i++) begin
            start   = (i == busy_start_at);
            pwr_off = (i == poff_at);
            if (i == busy_start_at) rate_i = 11'd10;
            @(negedge clk);
        end
        start   = 1'b0;
        pwr_off = 1'b0;
        chk("R8 done after sequence", done, 1);
        chk("R8 busy after sequence", busy, 0);
        chk("R7 write count", cq.size(), 7);
        chk("R7 data count", dq.size(), 7);
        for (int k = 0; k < 7 && k < cq.size() && k < dq.size(); k++) begin
            chk("R7 write code", cq[k], exp_code(k));
            if (k >= 1 && k <= 4) chk("R1 band code in lane data", dq[k], ec * 2);
            else                  chk("R7 write data", dq[k], exp_data(k, ec));
        end
        if (poff_at > 0) chk("R10 lane_en cleared", lane_en, 0);
        else             chk("R4 lane mask", lane_en, (1 << lanes) - 1);
        if (busy_start_at > 0) chk("R9 code kept despite start", dq.size() > 1 ? dq[1] : -1, ec * 2);
    endtask

    task automatic refuse(int rate, int lanes);
        cq.delete();
        dq.delete();
        @(negedge clk);
        rate_i  = 11'(rate);
        lanes_i = 3'(lanes);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 error raised", error, 1);
        chk("R2 busy stays low", busy, 0);
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R2 no test-port activity", cq.size(), 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_on = 1'b1;
        chk("R11 reset outputs", {lane_en, turn_dis, test_din, test_clk, busy, done, error}, 0);
        @(negedge clk);
        rst = 1'b0;

        run(80, 1, 0, 0);
        // R10 power-off while idle
        @(negedge clk); pwr_off = 1'b1;
        @(negedge clk); pwr_off = 1'b0;
        chk("R10 lane_en after idle power-off", lane_en, 0);
        run(90, 2, 0, 0);
        refuse(1501, 4);
        run(1500, 4, 30, 0);
        refuse(500, 0);
        refuse(500, 5);
        run(250, 3, 0, 100);
        run(0, 4, 0, 0);
        run(1449, 2, 75, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule